// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Arbiter

This block sits between the interrupt state store of a multi-processor interrupt controller and the request lines of the processors. It looks at every interrupt source on every clock, separately for each CPU. For each CPU it finds the most urgent source that is both enabled and pending for that CPU. It then decides two things: whether to report that source as the CPU's highest-pending interrupt, and whether to raise the CPU's request line.

The decision uses two separate thresholds. A per-CPU priority mask decides whether a candidate is reported at all. The CPU's running priority, the priority of the interrupt it is already servicing, decides whether the line goes high. The first 32 sources take their priority from a bank that is duplicated per CPU. All higher sources share one table.

All results are recomputed from the inputs every cycle and registered once. The reported ID and the request line of a CPU therefore change on the same clock edge, one cycle after the inputs change.

Top module: `irq_select_arbiter`

## Requirements
- R1: A lower priority value is more urgent. Among the qualifying sources of a CPU, the one with the smallest priority value is selected.
- R2: When several qualifying sources share the smallest priority value, the lowest-numbered source is selected.
- R3: When no source qualifies for a CPU, its reported ID is 1023 and its request line is low.
- R4: When the global enable is low, or the CPU's interface enable is low, that CPU reports 1023 and its line is low. This holds whatever sources are pending.
- R5: A selected candidate is reported only if its priority is less than or equal to the CPU's mask. A candidate with priority above the mask gives 1023 and a low line.
- R6: The request line is high only when the reported candidate's priority is strictly below the CPU's running priority. If the priorities are equal, the ID is still reported but the line stays low.
- R7: Sources 0 to 31 use the priority byte of the CPU's own bank. Sources 32 and above use the shared table.
- R8: A source qualifies for a CPU only when both its enable bit and its pending bit for that CPU are set. Bit c of source s sits at vector position s*N_CPU+c.
- R9: After reset every CPU reports 1023 with the line low. Outputs reflect the inputs exactly one clock after they are applied, and the ID and the line change together.
- R10: A running priority of 0x100 means idle. Any reported candidate then raises the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_en | input | 1 | Global forwarding enable |
| cpu_if_en | input | N_CPU | Per-CPU interface enable |
| src_enable | input | N_SRC*N_CPU | Enable bits; bit s*N_CPU+c belongs to source s, CPU c |
| src_pending | input | N_SRC*N_CPU | Pending bits, same layout as src_enable |
| prio_banked | input | N_CPU*32*8 | Banked priorities; byte c*32+s is source s (<32) for CPU c |
| prio_shared | input | (N_SRC-32)*8 | Shared priorities; byte s-32 is source s (>=32) |
| prio_mask | input | N_CPU*8 | Per-CPU priority mask, byte c for CPU c |
| run_prio | input | N_CPU*9 | Per-CPU running priority, 9 bits each, 0x100 = idle |
| best_id | output | N_CPU*10 | Per-CPU highest-pending ID, 10 bits each, 1023 = none |
| irq_out | output | N_CPU | Per-CPU request line |

## Verification
The bench builds the block with 64 sources and 2 CPUs. At that size there are banked sources below 32 and shared sources above it, so the bank/shared split of R7 is exercised. Two CPUs are enough to show that a pending bit, a bank entry or an interface enable of one CPU never reaches the other. Using the highest source, 63, reaches the last comparison stage of the scan, and setting both priority and threshold to 0 reaches the boundary compares at their extreme.

// File: rtl/irqsel_pkg.sv
// Shared widths and constants of the pending interrupt arbiter.
package irqsel_pkg;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = 9;
    localparam int ID_W   = 10;
    localparam int BANKED = 32;
    localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
endpackage

// File: rtl/irqsel_cand.sv
// Builds one CPU's view of the sources: the qualifying mask and a flat
// priority vector. Assumes the banked slice passed in is this CPU's.
module irqsel_cand
    import irqsel_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_CPU  = 2,
    parameter int CPU_IX = 0,
    localparam int N_SHR = (N_SRC > BANKED) ? N_SRC - BANKED : 1
) (
    input  logic [N_SRC*N_CPU-1:0]  src_enable,
    input  logic [N_SRC*N_CPU-1:0]  src_pending,
    input  logic [BANKED*PRIO_W-1:0] bank_prio,
    input  logic [N_SHR*PRIO_W-1:0] shared_prio,
    output logic [N_SRC-1:0]        cand,
    output logic [N_SRC*PRIO_W-1:0] prio_vec
);
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        // qualify: enabled and pending for this CPU
        assign cand[s] = src_enable[s*N_CPU+CPU_IX] & src_pending[s*N_CPU+CPU_IX];
        if (s < BANKED) begin : g_bank
            // low sources read the CPU's own bank
            assign prio_vec[s*PRIO_W +: PRIO_W] = bank_prio[s*PRIO_W +: PRIO_W];
        end else begin : g_shr
            // high sources read the shared table
            assign prio_vec[s*PRIO_W +: PRIO_W] = shared_prio[(s-BANKED)*PRIO_W +: PRIO_W];
        end
    end
endmodule

// File: rtl/irqsel_scan.sv
// Linear minimum search over all sources. Assumes lower value = more
// urgent; only a strictly smaller value replaces the current best.
module irqsel_scan
    import irqsel_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*PRIO_W-1:0] prio_vec,
    output logic                    found,
    output logic [ID_W-1:0]         win_id,
    output logic [PRIO_W-1:0]       win_prio
);
    // walk upward; ties keep the earlier source
    always_comb begin
        found    = 1'b0;
        win_id   = NONE_ID;
        win_prio = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand[i] && (!found || prio_vec[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_id   = i[ID_W-1:0];
                win_prio = prio_vec[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // R8: a winner must be a qualifying source
    a_r8_winner_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (win_id < ID_W'(N_SRC)) && cand[win_id[$clog2(N_SRC)-1:0]]);
    // R3: no candidates means no winner
    a_r3_empty_no_win: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> !found);
endmodule

// File: rtl/irqsel_gate.sv
// Applies the mask and running-priority thresholds for one CPU and
// registers the ID and request line together.
module irqsel_gate
    import irqsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              found,
    input  logic [ID_W-1:0]   win_id,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic [PRIO_W-1:0] mask,
    input  logic [RUN_W-1:0]  run_prio,
    output logic [ID_W-1:0]   id_q,
    output logic              irq_q
);
    logic [ID_W-1:0] id_d;
    logic            irq_d;

    // threshold decision for the next cycle
    always_comb begin
        id_d  = NONE_ID;
        irq_d = 1'b0;
        if (en && found && win_prio <= mask) begin
            id_d  = win_id;
            irq_d = {1'b0, win_prio} < run_prio;
        end
    end

    // output register, ID and line move on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= NONE_ID;
            irq_q <= 1'b0;
        end else begin
            id_q  <= id_d;
            irq_q <= irq_d;
        end
    end

    // R4: disabled interface stays quiet
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (id_q == NONE_ID) && !irq_q);
    // R3: a raised line always has a real ID
    a_r3_line_has_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> id_q != NONE_ID);
    // R5: winner above the mask is not reported
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (found && win_prio > mask) |=> (id_q == NONE_ID) && !irq_q);
    // R6: equal or worse than running reports but keeps line low
    a_r6_running_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (en && found && win_prio <= mask && {1'b0, win_prio} >= run_prio)
        |=> !irq_q && id_q == $past(win_id));
endmodule

// File: rtl/irq_select_arbiter.sv
// Top: one candidate builder, scanner and threshold gate per CPU.
// Assumes N_SRC is a multiple of 32 and at least 64, N_CPU in 1..4.
module irq_select_arbiter
    import irqsel_pkg::*;
#(
    parameter int N_SRC = 64,
    parameter int N_CPU = 2,
    localparam int N_SHR = (N_SRC > BANKED) ? N_SRC - BANKED : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            dist_en,
    input  logic [N_CPU-1:0]                cpu_if_en,
    input  logic [N_SRC*N_CPU-1:0]          src_enable,
    input  logic [N_SRC*N_CPU-1:0]          src_pending,
    input  logic [N_CPU*BANKED*PRIO_W-1:0]  prio_banked,
    input  logic [N_SHR*PRIO_W-1:0]         prio_shared,
    input  logic [N_CPU*PRIO_W-1:0]         prio_mask,
    input  logic [N_CPU*RUN_W-1:0]          run_prio,
    output logic [N_CPU*ID_W-1:0]           best_id,
    output logic [N_CPU-1:0]                irq_out
);
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [N_SRC-1:0]        cand;
        logic [N_SRC*PRIO_W-1:0] prio_vec;
        logic                    found;
        logic [ID_W-1:0]         win_id;
        logic [PRIO_W-1:0]       win_prio;

        irqsel_cand #(.N_SRC(N_SRC), .N_CPU(N_CPU), .CPU_IX(c)) u_cand (
            .src_enable (src_enable),
            .src_pending(src_pending),
            .bank_prio  (prio_banked[c*BANKED*PRIO_W +: BANKED*PRIO_W]),
            .shared_prio(prio_shared),
            .cand       (cand),
            .prio_vec   (prio_vec)
        );

        irqsel_scan #(.N_SRC(N_SRC)) u_scan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cand    (cand),
            .prio_vec(prio_vec),
            .found   (found),
            .win_id  (win_id),
            .win_prio(win_prio)
        );

        irqsel_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (dist_en & cpu_if_en[c]),
            .found   (found),
            .win_id  (win_id),
            .win_prio(win_prio),
            .mask    (prio_mask[c*PRIO_W +: PRIO_W]),
            .run_prio(run_prio[c*RUN_W +: RUN_W]),
            .id_q    (best_id[c*ID_W +: ID_W]),
            .irq_q   (irq_out[c])
        );
    end
endmodule

// File: tb/irq_select_arbiter_bench.sv
module irq_select_arbiter_bench;
    localparam int N_SRC = 64;
    localparam int N_CPU = 2;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dist_en;
    logic [N_CPU-1:0] cpu_if_en;
    logic [N_SRC*N_CPU-1:0] src_enable, src_pending;
    logic [N_CPU*32*8-1:0] prio_banked;
    logic [(N_SRC-32)*8-1:0] prio_shared;
    logic [N_CPU*8-1:0] prio_mask;
    logic [N_CPU*9-1:0] run_prio;
    logic [N_CPU*10-1:0] best_id;
    logic [N_CPU-1:0] irq_out;

    int checks = 0;
    int fails = 0;

    irq_select_arbiter #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_irq_select_arbiter (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
        .src_enable(src_enable), .src_pending(src_pending),
        .prio_banked(prio_banked), .prio_shared(prio_shared),
        .prio_mask(prio_mask), .run_prio(run_prio),
        .best_id(best_id), .irq_out(irq_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [5:0] sa; logic [7:0] pa;
        logic [5:0] sb; logic [7:0] pb;
        logic [7:0] mask; logic [8:0] run;
        logic [9:0] eid; logic eirq;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{6'd5,  8'h40, 6'd40, 8'h20, 8'hF0, 9'h100, 10'd40,   1'b1}, // R1
        '{6'd5,  8'h20, 6'd40, 8'h40, 8'hF0, 9'h100, 10'd5,    1'b1}, // R1
        '{6'd10, 8'h30, 6'd3,  8'h30, 8'hF0, 9'h100, 10'd3,    1'b1}, // R2
        '{6'd60, 8'h50, 6'd33, 8'h50, 8'hF0, 9'h100, 10'd33,   1'b1}, // R2
        '{6'd7,  8'h80, 6'd50, 8'h90, 8'h70, 9'h100, 10'd1023, 1'b0}, // R5
        '{6'd7,  8'h70, 6'd50, 8'h90, 8'h70, 9'h100, 10'd7,    1'b1}, // R5
        '{6'd7,  8'h60, 6'd50, 8'h90, 8'hF0, 9'h060, 10'd7,    1'b0}, // R6
        '{6'd7,  8'h60, 6'd50, 8'h90, 8'hF0, 9'h061, 10'd7,    1'b1}, // R6
        '{6'd63, 8'h00, 6'd0,  8'h01, 8'h00, 9'h000, 10'd63,   1'b0}, // R6
        '{6'd63, 8'hFF, 6'd1,  8'hFF, 8'hFF, 9'h100, 10'd1,    1'b1}  // R10
    };

    task automatic chk(input int c, input logic [9:0] eid, input logic eirq, input string req);
        logic [9:0] aid;
        aid = best_id[c*10 +: 10];
        checks++;
        if (aid !== eid || irq_out[c] !== eirq) begin
            fails++;
            $display("FAIL %s cpu%0d: id=%0d irq=%b expected id=%0d irq=%b", req, c, aid, irq_out[c], eid, eirq);
        end
    endtask

    task automatic clear_all();
        dist_en = 1'b1; cpu_if_en = '1;
        src_enable = '0; src_pending = '0;
        prio_banked = '1; prio_shared = '1;
        prio_mask = {N_CPU{8'hF0}}; run_prio = {N_CPU{9'h100}};
    endtask

    task automatic set_src(input int c, input int s, input logic [7:0] p);
        src_enable[s*N_CPU+c] = 1'b1;
        src_pending[s*N_CPU+c] = 1'b1;
        if (s < 32) prio_banked[(c*32+s)*8 +: 8] = p;
        else prio_shared[(s-32)*8 +: 8] = p;
    endtask

    // apply at negedge, sample at next negedge (one posedge later)
    task automatic settle();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_all();
        set_src(0, 4, 8'h10);
        repeat (3) @(negedge clk);
        chk(0, 10'd1023, 1'b0, "R9 reset");
        chk(1, 10'd1023, 1'b0, "R9 reset");
        rst_n = 1'b1;

        // table walk on CPU 0
        foreach (TBL[i]) begin
            clear_all();
            set_src(0, int'(TBL[i].sa), TBL[i].pa);
            set_src(0, int'(TBL[i].sb), TBL[i].pb);
            prio_mask[7:0] = TBL[i].mask;
            run_prio[8:0] = TBL[i].run;
            settle();
            chk(0, TBL[i].eid, TBL[i].eirq, "R1/R2/R5/R6/R10 table");
            chk(1, 10'd1023, 1'b0, "R8 other cpu untouched");
        end

        // R3: nothing pending
        clear_all(); settle();
        chk(0, 10'd1023, 1'b0, "R3 nothing pending");

        // R8: enable without pending, pending without enable
        clear_all();
        src_enable[9*N_CPU+0] = 1'b1; prio_banked[9*8 +: 8] = 8'h10;
        src_pending[45*N_CPU+0] = 1'b1; prio_shared[13*8 +: 8] = 8'h10;
        settle();
        chk(0, 10'd1023, 1'b0, "R8 half-qualified");

        // R8: source pending only for CPU 1
        clear_all(); set_src(1, 45, 8'h20); settle();
        chk(0, 10'd1023, 1'b0, "R8 cpu0 not targeted");
        chk(1, 10'd45, 1'b1, "R8 cpu1 targeted");

        // R7: banked per CPU vs shared
        clear_all();
        set_src(0, 4, 8'h80); set_src(1, 4, 8'h10);
        set_src(0, 40, 8'h40); set_src(1, 40, 8'h40);
        settle();
        chk(0, 10'd40, 1'b1, "R7 cpu0 bank");
        chk(1, 10'd4, 1'b1, "R7 cpu1 bank");

        // R4: interface enable off for CPU 1, then global off
        cpu_if_en = 2'b01; settle();
        chk(0, 10'd40, 1'b1, "R4 cpu0 still on");
        chk(1, 10'd1023, 1'b0, "R4 cpu1 interface off");
        cpu_if_en = 2'b11; dist_en = 1'b0; settle();
        chk(0, 10'd1023, 1'b0, "R4 global off");
        chk(1, 10'd1023, 1'b0, "R4 global off");

        // R9: one-cycle latency, both outputs move together
        dist_en = 1'b1;
        #1;
        chk(0, 10'd1023, 1'b0, "R9 before edge");
        settle();
        chk(0, 10'd40, 1'b1, "R9 after edge");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule